// File: doc/BRIEF.md
# Pipeline Advance Controller

This block decides, cycle by cycle, which stages of a multi-unit processor pipeline may move forward. It drives one advance enable each for instruction fetch, decode, the issue step and write-back, plus one reservation-station load enable for each of four execution classes. All enables are combinational functions of the current status inputs and two small registers: a reset-release flag and a single-step phase.

Issue is built from one shared "an execution unit can take this instruction" term. The order-buffer push (`adv_iss_o`) and the load of the single reservation station named by the decoded unit type therefore always rise and fall together. While a delayed second-register write-back is in flight, decode and write-back are both frozen. A simplified single-step mode walks a one-hot phase through fetch/decode, issue and write-back, then returns to idle.

Top module: `pipe_adv_ctrl`

## Requirements
- R1: While `rst` is high, and after its release until the first rising clock edge that samples it low, every advance output is 0 and `sstep_phase_o` is 3'b000.
- R2: With single-step off, `adv_fetch_o` equals `glb_go_i`. When `glb_go_i` is 0, no advance output is asserted in any mode.
- R3: With single-step off, `adv_dec_o` = `glb_go_i` & ~`wb2_busy_i` & `dec_free_i` & (`dec_empty_i` | `adv_iss_o`).
- R4: While `wb2_busy_i` is 1, `adv_dec_o` and `adv_wb_o` are 0. `adv_fetch_o` is not affected.
- R5: With single-step off, `adv_iss_o` = `glb_go_i` & `iss_valid_i` & `rs_ready_i[iss_unit_i]`.
- R6: Unit codes are 0 single-cycle integer, 1 mul/div, 2 floating point and 3 load/store. `adv_rs_o[k]` is 1 exactly when `adv_iss_o` is 1 and `iss_unit_i` equals k. At most one bit is set, and the OR of the bits equals `adv_iss_o`.
- R7: With single-step off, `adv_wb_o` = `glb_go_i` & ~`wb2_busy_i` & (`ex_valid_i` | `spr_valid_i`).
- R8: The single-step phase moves as follows. From 3'b000, with single-step on and `sstep_kick_i` high, it goes to 3'b001 at the next clock edge. It then goes to 3'b010 on an edge where `adv_dec_o` is 1, to 3'b100 on an edge where `adv_iss_o` is 1, and back to 3'b000 on an edge where `adv_wb_o` is 1. In every other case it holds, and it is always one-hot or zero.
- R9: With single-step on, fetch and decode advance only in phase 3'b001 and only with `dec_empty_i` high. Issue is allowed only in phase 3'b010, and write-back only in phase 3'b100.
- R10: With single-step off, the phase is forced to 3'b000 at the next clock edge, and `sstep_kick_i` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| glb_go_i | input | 1 | Global permission to advance |
| sstep_en_i | input | 1 | Single-step mode on |
| sstep_kick_i | input | 1 | Start one single-step walk |
| dec_empty_i | input | 1 | Decode stage holds no instruction |
| dec_free_i | input | 1 | Decode stage may output operands |
| iss_valid_i | input | 1 | Decoded instruction is ready to issue |
| iss_unit_i | input | 2 | Execution class of decoded instruction |
| rs_ready_i | input | 4 | Per-class reservation station can accept |
| ex_valid_i | input | 1 | Oldest instruction has a result |
| spr_valid_i | input | 1 | Special-register move result valid |
| wb2_busy_i | input | 1 | Delayed second-destination write pending |
| adv_fetch_o | output | 1 | Fetch advance |
| adv_dec_o | output | 1 | Decode advance |
| adv_iss_o | output | 1 | Issue advance / order-buffer push |
| adv_rs_o | output | 4 | Per-class reservation-station load |
| adv_wb_o | output | 1 | Write-back advance |
| sstep_phase_o | output | 3 | Single-step phase, one-hot or zero |

## Verification
Decode is driven through all eight combinations of free, empty and issue-possible. This separates the "empty" path from the "vacating by issue" path. Issue is tried for each unit code, once with every station ready and once with only the named station blocked. That test shows whether the station is picked by index and whether the select lines stay one-hot. The write-back sources are applied one at a time and together, and the second-write stall is then raised over a fully permissive input set. This shows the stall reaching decode and write-back but not fetch. A complete single-step walk, including a stall in the first phase and an early exit from the mode, checks each phase transition and each stage's gating.

// File: rtl/pipe_adv_pkg.sv
`timescale 1ns/1ps
package pipe_adv_pkg;
  localparam int NUM_UNITS = 4;

  typedef enum logic [1:0] {
    UNIT_ALU    = 2'd0,
    UNIT_MULDIV = 2'd1,
    UNIT_FPU    = 2'd2,
    UNIT_LSU    = 2'd3
  } unit_e;

  // one-hot phase bit positions
  localparam int PH_FD = 0;
  localparam int PH_IS = 1;
  localparam int PH_WB = 2;
  localparam int PH_W  = 3;

  // stage gate outside / inside single step for fetch
  function automatic logic fetch_gate(input logic step, input logic empty,
                                      input logic ph_fd);
    return step ? (empty & ph_fd) : 1'b1;
  endfunction

  // decode gate: free stage that empties or vacates by issue
  function automatic logic dec_gate(input logic step, input logic free,
                                    input logic empty, input logic iss,
                                    input logic ph_fd);
    return step ? (empty & ph_fd) : (free & (empty | iss));
  endfunction

  // a stage allowed in single step only in its own phase
  function automatic logic phase_gate(input logic step, input logic ph_bit);
    return ~step | ph_bit;
  endfunction
endpackage

// File: rtl/pac_step_seq.sv
`timescale 1ns/1ps
module pac_step_seq
  import pipe_adv_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            step_en,
  input  logic            kick,
  input  logic            dec_adv,
  input  logic            iss_adv,
  input  logic            wb_adv,
  output logic [PH_W-1:0] phase
);
  logic [PH_W-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!step_en) begin
      phase_d = '0;
    end else if (phase_q == '0) begin
      if (kick) phase_d = PH_W'(1) << PH_FD;
    end else if (phase_q[PH_FD] && dec_adv) begin
      phase_d = PH_W'(1) << PH_IS;
    end else if (phase_q[PH_IS] && iss_adv) begin
      phase_d = PH_W'(1) << PH_WB;
    end else if (phase_q[PH_WB] && wb_adv) begin
      phase_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/pac_issue_sel.sv
`timescale 1ns/1ps
module pac_issue_sel #(
  parameter int N_UNITS = 4,
  localparam int UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               allow,
  input  logic               valid,
  input  logic [UNIT_W-1:0]  unit,
  input  logic [N_UNITS-1:0] ready,
  output logic               iss_adv,
  output logic [N_UNITS-1:0] rs_adv
);
  logic unit_can_take;

  always_comb begin
    unit_can_take = 1'b0;
    for (int k = 0; k < N_UNITS; k++)
      if (unit == UNIT_W'(k)) unit_can_take = ready[k];
  end

  // shared term: push and station load come from the same signal
  assign iss_adv = allow & valid & unit_can_take;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_rs
    assign rs_adv[g] = iss_adv & (unit == UNIT_W'(g));
  end
endmodule

// File: rtl/pipe_adv_ctrl.sv
`timescale 1ns/1ps
module pipe_adv_ctrl
  import pipe_adv_pkg::*;
#(
  parameter int N_UNITS = NUM_UNITS,
  localparam int UNIT_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               glb_go_i,
  input  logic               sstep_en_i,
  input  logic               sstep_kick_i,
  input  logic               dec_empty_i,
  input  logic               dec_free_i,
  input  logic               iss_valid_i,
  input  logic [UNIT_W-1:0]  iss_unit_i,
  input  logic [N_UNITS-1:0] rs_ready_i,
  input  logic               ex_valid_i,
  input  logic               spr_valid_i,
  input  logic               wb2_busy_i,
  output logic               adv_fetch_o,
  output logic               adv_dec_o,
  output logic               adv_iss_o,
  output logic [N_UNITS-1:0] adv_rs_o,
  output logic               adv_wb_o,
  output logic [PH_W-1:0]    sstep_phase_o
);
  logic            live_q;
  logic [PH_W-1:0] phase;
  logic            go_live;
  logic            iss_allow;
  logic            iss_adv;
  logic            wb_src;

  always_ff @(posedge clk) begin
    if (rst) live_q <= 1'b0;
    else     live_q <= 1'b1;
  end

  assign go_live   = live_q & glb_go_i;
  assign iss_allow = go_live & phase_gate(sstep_en_i, phase[PH_IS]);
  assign wb_src    = ex_valid_i | spr_valid_i;

  pac_issue_sel #(.N_UNITS(N_UNITS)) u_iss (
    .allow   (iss_allow),
    .valid   (iss_valid_i),
    .unit    (iss_unit_i),
    .ready   (rs_ready_i),
    .iss_adv (iss_adv),
    .rs_adv  (adv_rs_o)
  );

  assign adv_iss_o   = iss_adv;
  assign adv_fetch_o = go_live & fetch_gate(sstep_en_i, dec_empty_i, phase[PH_FD]);
  assign adv_dec_o   = go_live & ~wb2_busy_i &
                       dec_gate(sstep_en_i, dec_free_i, dec_empty_i, iss_adv, phase[PH_FD]);
  assign adv_wb_o    = go_live & ~wb2_busy_i & wb_src &
                       phase_gate(sstep_en_i, phase[PH_WB]);

  pac_step_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .step_en (sstep_en_i),
    .kick    (sstep_kick_i),
    .dec_adv (adv_dec_o),
    .iss_adv (adv_iss_o),
    .wb_adv  (adv_wb_o),
    .phase   (phase)
  );

  assign sstep_phase_o = phase;
endmodule

// File: rtl/pipe_adv_ctrl_chk.sv
`timescale 1ns/1ps
module pipe_adv_ctrl_chk #(
  parameter int N_UNITS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               glb_go_i,
  input logic               sstep_en_i,
  input logic               wb2_busy_i,
  input logic               adv_fetch_o,
  input logic               adv_dec_o,
  input logic               adv_iss_o,
  input logic [N_UNITS-1:0] adv_rs_o,
  input logic               adv_wb_o,
  input logic [2:0]         sstep_phase_o
);
  p_rst_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !(adv_fetch_o || adv_dec_o || adv_iss_o || adv_wb_o || (|adv_rs_o)));

  p_no_go_r2: assert property (@(posedge clk) disable iff (rst)
    !glb_go_i |-> !(adv_fetch_o || adv_dec_o || adv_iss_o || adv_wb_o || (|adv_rs_o)));

  p_wb2_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    wb2_busy_i |-> !(adv_dec_o || adv_wb_o));

  p_rs_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(adv_rs_o) && ((|adv_rs_o) == adv_iss_o));

  p_phase_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sstep_phase_o));

  p_wb_return_r8: assert property (@(posedge clk) disable iff (rst)
    (adv_wb_o && sstep_phase_o[2]) |=> (sstep_phase_o == 3'b000));

  p_step_fetch_r9: assert property (@(posedge clk) disable iff (rst)
    (sstep_en_i && !sstep_phase_o[0]) |-> !(adv_fetch_o || adv_dec_o));

  p_step_wb_r9: assert property (@(posedge clk) disable iff (rst)
    (sstep_en_i && !sstep_phase_o[2]) |-> !adv_wb_o);

  p_step_off_r10: assert property (@(posedge clk) disable iff (rst)
    !sstep_en_i |=> (sstep_phase_o == 3'b000));
endmodule

bind pipe_adv_ctrl pipe_adv_ctrl_chk #(.N_UNITS(N_UNITS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .glb_go_i      (glb_go_i),
  .sstep_en_i    (sstep_en_i),
  .wb2_busy_i    (wb2_busy_i),
  .adv_fetch_o   (adv_fetch_o),
  .adv_dec_o     (adv_dec_o),
  .adv_iss_o     (adv_iss_o),
  .adv_rs_o      (adv_rs_o),
  .adv_wb_o      (adv_wb_o),
  .sstep_phase_o (sstep_phase_o)
);

// File: tb/pipe_adv_ctrl_tb.sv
`timescale 1ns/1ps
module pipe_adv_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       glb_go_i, sstep_en_i, sstep_kick_i;
  logic       dec_empty_i, dec_free_i, iss_valid_i;
  logic [1:0] iss_unit_i;
  logic [3:0] rs_ready_i;
  logic       ex_valid_i, spr_valid_i, wb2_busy_i;
  logic       adv_fetch_o, adv_dec_o, adv_iss_o, adv_wb_o;
  logic [3:0] adv_rs_o;
  logic [2:0] sstep_phase_o;

  int n_vec = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  pipe_adv_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic benign();
    glb_go_i = 1'b1; sstep_en_i = 1'b0; sstep_kick_i = 1'b0;
    dec_empty_i = 1'b1; dec_free_i = 1'b1; iss_valid_i = 1'b0;
    iss_unit_i = 2'd0; rs_ready_i = 4'h0;
    ex_valid_i = 1'b0; spr_valid_i = 1'b0; wb2_busy_i = 1'b0;
  endtask

  function automatic logic [7:0] all_adv();
    return {adv_fetch_o, adv_dec_o, adv_iss_o, adv_rs_o, adv_wb_o};
  endfunction

  task automatic t_reset();
    benign(); iss_valid_i = 1'b1; rs_ready_i = 4'hF; ex_valid_i = 1'b1;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1 outputs in reset", all_adv(), 8'h00);
    chk("R1 phase in reset", {5'd0, sstep_phase_o}, 8'h00);
    @(negedge clk); rst = 1'b0; #1;
    chk("R1 outputs before first live edge", all_adv(), 8'h00);
    @(negedge clk); #1;
    chk("R1 outputs live after edge", {7'd0, adv_fetch_o}, 8'h01);
  endtask

  task automatic t_fetch();
    for (int g = 0; g < 2; g++) begin
      @(negedge clk); benign(); glb_go_i = g[0];
      iss_valid_i = 1'b1; rs_ready_i = 4'hF; ex_valid_i = 1'b1; #1;
      chk("R2 fetch follows go", {7'd0, adv_fetch_o}, {7'd0, g[0]});
      if (g == 0) chk("R2 nothing without go", all_adv(), 8'h00);
    end
  endtask

  task automatic t_decode();
    for (int c = 0; c < 8; c++) begin
      @(negedge clk); benign();
      dec_free_i = c[0]; dec_empty_i = c[1]; iss_valid_i = c[2]; rs_ready_i = 4'hF; #1;
      chk("R3 decode advance", {7'd0, adv_dec_o}, {7'd0, c[0] & (c[1] | c[2])});
    end
  endtask

  task automatic t_issue();
    for (int u = 0; u < 4; u++) begin
      for (int m = 0; m < 2; m++) begin
        logic [3:0] mask;
        logic       exp_iss;
        mask = (m == 0) ? 4'hF : (4'hF & ~(4'h1 << u));
        exp_iss = mask[u];
        @(negedge clk); benign();
        iss_valid_i = 1'b1; iss_unit_i = u[1:0]; rs_ready_i = mask; #1;
        chk("R5 issue advance", {7'd0, adv_iss_o}, {7'd0, exp_iss});
        chk("R6 station select", {4'd0, adv_rs_o}, {4'd0, exp_iss ? (4'h1 << u) : 4'h0});
      end
    end
    @(negedge clk); benign(); iss_valid_i = 1'b0; rs_ready_i = 4'hF; #1;
    chk("R5 no issue without valid", {3'd0, adv_iss_o, adv_rs_o}, 8'h00);
  endtask

  task automatic t_wb();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); benign(); ex_valid_i = c[0]; spr_valid_i = c[1]; #1;
      chk("R7 write-back advance", {7'd0, adv_wb_o}, {7'd0, c[0] | c[1]});
    end
  endtask

  task automatic t_wb2();
    @(negedge clk); benign();
    ex_valid_i = 1'b1; iss_valid_i = 1'b1; rs_ready_i = 4'hF; wb2_busy_i = 1'b1; #1;
    chk("R4 decode frozen", {7'd0, adv_dec_o}, 8'h00);
    chk("R4 write-back frozen", {7'd0, adv_wb_o}, 8'h00);
    chk("R4 fetch unaffected", {7'd0, adv_fetch_o}, 8'h01);
    @(negedge clk); wb2_busy_i = 1'b0; #1;
    chk("R4 released", {6'd0, adv_dec_o, adv_wb_o}, 8'h03);
  endtask

  task automatic t_step();
    @(negedge clk); benign();
    sstep_en_i = 1'b1; iss_valid_i = 1'b1; iss_unit_i = 2'd2; rs_ready_i = 4'hF;
    ex_valid_i = 1'b1; #1;
    chk("R9 idle phase blocks all", all_adv(), 8'h00);
    @(negedge clk); sstep_kick_i = 1'b1; #1;
    chk("R8 still idle before edge", {5'd0, sstep_phase_o}, 8'h00);
    @(negedge clk); sstep_kick_i = 1'b0; dec_empty_i = 1'b0; #1;
    chk("R8 kick enters fetch phase", {5'd0, sstep_phase_o}, 8'h01);
    chk("R9 decode not empty stalls", all_adv(), 8'h00);
    @(negedge clk); dec_empty_i = 1'b1; #1;
    chk("R8 held while stalled", {5'd0, sstep_phase_o}, 8'h01);
    chk("R9 fetch+decode only", all_adv(), 8'hC0);
    @(negedge clk); #1;
    chk("R8 issue phase", {5'd0, sstep_phase_o}, 8'h01 << 1);
    chk("R9 issue only, unit 2", all_adv(), 8'h28);
    @(negedge clk); #1;
    chk("R8 write-back phase", {5'd0, sstep_phase_o}, 8'h04);
    chk("R9 write-back only", all_adv(), 8'h01);
    @(negedge clk); #1;
    chk("R8 back to idle", {5'd0, sstep_phase_o}, 8'h00);
    chk("R9 idle again blocks", all_adv(), 8'h00);
  endtask

  task automatic t_step_exit();
    @(negedge clk); benign(); sstep_en_i = 1'b1; sstep_kick_i = 1'b1; dec_empty_i = 1'b0;
    @(negedge clk); sstep_kick_i = 1'b0; sstep_en_i = 1'b0; #1;
    chk("R8 entered fetch phase", {5'd0, sstep_phase_o}, 8'h01);
    chk("R2 normal fetch with step off", {7'd0, adv_fetch_o}, 8'h01);
    @(negedge clk); #1;
    chk("R10 phase cleared on exit", {5'd0, sstep_phase_o}, 8'h00);
    @(negedge clk); sstep_kick_i = 1'b1; #1;
    @(negedge clk); sstep_kick_i = 1'b0; #1;
    chk("R10 kick ignored when off", {5'd0, sstep_phase_o}, 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_fetch();
        t_decode();
        t_issue();
        t_wb();
        t_wb2();
        t_step();
        t_step_exit();
      end
      begin
        repeat (100000) @(posedge clk);
        n_vec++; n_err++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule